// File: doc/BRIEF.md
# Compare-Triggered Conversion Start Controller

This block paces a sampling converter from a hardware timer. A free-running 16-bit timer is compared against a programmable 16-bit compare value. When the compare unit is in its special-event mode and the timer equals the compare value, the timer returns to zero on that clock edge. If the converter is enabled and idle, the same edge also starts an acquire-then-convert sequence. Software programs the period, the acquisition time and the conversion clock once, and the block then delivers a new sample every period with no further software action.

The converter is modelled digitally. An acquisition phase and an 11-period conversion phase are counted in conversion-clock periods. At the end of the conversion, the value on the digital sample input is latched into the result register. The result is presented right- or left-justified in a 16-bit word that can be read as a high byte and a low byte. A sticky done flag is raised at completion. Software can also start a conversion directly, or abort one, through the control register.

Register map (8-bit bus, 3-bit address). Reserved bits read as 0.

| Address | Register | Layout |
|---|---|---|
| 0 | control | bit 0 enable, bit 1 busy/start, bits 5:2 channel, bit 7 done flag |
| 1 | config | bits 2:0 clock code, bits 5:3 acquisition code, bit 7 justification (1 = right) |
| 2 | compare mode | bits 3:0 |
| 3 | compare value | low byte |
| 4 | compare value | high byte |
| 5 | result | high byte, read-only |
| 6 | result | low byte, read-only |
| 7 | timer | low byte, read-only |

Top module: `convtrig_ctrl`

## Requirements
- R1: After reset, all of the following are 0: every register read at addresses 0 to 7, `done_flag`, `result` and `chan_sel`.
- R2: When the compare mode is not binary 1011, the timer advances by one every clock and does not return to zero at the compare value.
- R3: When the compare mode is binary 1011, the edge on which the timer equals the compare value sets the timer to 0. The trigger therefore repeats every compare+1 cycles, and the timer also wraps from all ones to 0.
- R4: A trigger that occurs while the converter is enabled and idle sets busy (control bit 1) on the same clock edge that zeroes the timer.
- R5: A trigger that occurs while enable (control bit 0) is 0 leaves busy at 0 but still zeroes the timer.
- R6: A conversion keeps busy at 1 for (A+11)·2^K clock cycles. K is the clock code (config bits 2:0). A is 0, 2, 4, 6, 8, 12, 16 or 20 for acquisition codes 0 to 7 (config bits 5:3).
- R7: On the edge where busy falls at the end of a conversion, the result register takes `sample_in` and `done_flag` becomes 1.
- R8: Config bit 7 set to 1 presents the 10-bit result in bits 9:0 of the 16-bit word. Set to 0, it presents the result in bits 15:6. Changing the bit re-justifies the stored result.
- R9: A trigger that arrives during a conversion neither restarts nor ends it, but it does zero the timer.
- R10: Writing control with bits 1 and 0 both set starts a conversion from idle. Writing bit 1 set while bit 0 is 0 starts nothing.
- R11: During a conversion, a control write with bit 1 or bit 0 clear aborts it. The result register then stays unchanged and `done_flag` stays 0.
- R12: `done_flag` stays set until a control write with bit 7 clear. A control write with bit 7 set leaves it at 1.
- R13: `chan_sel` and control bits 5:2 follow the last written channel field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | 3 | register address |
| bus_wr | input | 1 | write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, combinational from `bus_addr` |
| sample_in | input | 10 | digital stand-in for the converter input |
| chan_sel | output | 4 | selected input channel |
| done_flag | output | 1 | sticky conversion-complete flag |
| result | output | 16 | justified conversion result |

## Verification
Every result has a fixed due cycle, counted from the edge that applies the stimulus:
- A bus write takes effect on the same edge it is sampled.
- The timer reads 0 on the edge after it showed the compare value. With equal or unchanged values, the trigger falls every compare+1 edges after the compare write.
- Busy rises on the trigger edge itself.
- Busy falls, and the result and flag update, exactly (A+11)·2^K edges later.

The bench counts clock edges from the edge that applied each stimulus. It samples on falling edges at the last cycle before each change and at the first cycle after it, so an early or late transition by even one cycle is reported.

// File: rtl/convtrig_pkg.sv
package convtrig_pkg;

    localparam int BUS_W         = 8;
    localparam int CHAN_W        = 4;
    localparam int RES_W         = 16;
    localparam int ACQ_TAD_MAX   = 20;
    localparam int TAD_SHIFT_MAX = 7;

    localparam logic [3:0] MODE_SPECIAL = 4'b1011;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_CFG    = 3'd1,
        A_MODE   = 3'd2,
        A_CMP_LO = 3'd3,
        A_CMP_HI = 3'd4,
        A_RES_HI = 3'd5,
        A_RES_LO = 3'd6,
        A_TMR_LO = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ACQ,
        SEQ_CONV
    } seq_state_e;

    typedef struct packed {
        logic              flag;
        logic              rsvd;
        logic [CHAN_W-1:0] chan;
        logic              go;
        logic              en;
    } ctrl_view_t;

    typedef struct packed {
        logic       right_just;
        logic       rsvd;
        logic [2:0] acq;
        logic [2:0] tad;
    } cfg_t;

    // acquisition length in conversion-clock periods for each code
    function automatic logic [4:0] acq_tad(input logic [2:0] code);
        logic [4:0] n;
        case (code)
            3'd0:    n = 5'd0;
            3'd1:    n = 5'd2;
            3'd2:    n = 5'd4;
            3'd3:    n = 5'd6;
            3'd4:    n = 5'd8;
            3'd5:    n = 5'd12;
            3'd6:    n = 5'd16;
            default: n = 5'd20;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/convtrig_timer.sv
module convtrig_timer
    import convtrig_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       mode,
    input  logic [TMR_W-1:0] cmp,
    output logic [TMR_W-1:0] tmr,
    output logic             trig
);

    always_comb begin
        trig = (mode == MODE_SPECIAL) && (tmr == cmp);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr <= '0;
        end else if (trig) begin
            tmr <= '0;
        end else begin
            tmr <= tmr + 1'b1;
        end
    end

endmodule

// File: rtl/convtrig_seq.sv
module convtrig_seq
    import convtrig_pkg::*;
#(
    parameter int SMP_W    = 10,
    parameter int CONV_TAD = 11,
    parameter int CNT_W    = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             abort,
    input  logic [2:0]       acq_code,
    input  logic [2:0]       tad_code,
    input  logic [SMP_W-1:0] sample,
    output logic             busy,
    output logic             finish,
    output logic [SMP_W-1:0] raw
);

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] acq_cyc;
    logic [CNT_W-1:0] conv_cyc;
    logic             last;

    always_comb begin
        acq_cyc  = CNT_W'(acq_tad(acq_code)) << tad_code;
        conv_cyc = CNT_W'(CONV_TAD) << tad_code;
        last     = (cnt == CNT_W'(1));
        busy     = (st != SEQ_IDLE);
        finish   = (st == SEQ_CONV) && last && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
            raw <= '0;
        end else if (abort) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SEQ_IDLE: begin
                    if (start) begin
                        if (acq_cyc == '0) begin
                            st  <= SEQ_CONV;
                            cnt <= conv_cyc;
                        end else begin
                            st  <= SEQ_ACQ;
                            cnt <= acq_cyc;
                        end
                    end
                end
                SEQ_ACQ: begin
                    if (last) begin
                        st  <= SEQ_CONV;
                        cnt <= conv_cyc;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                SEQ_CONV: begin
                    if (last) begin
                        st  <= SEQ_IDLE;
                        cnt <= '0;
                        raw <= sample;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    st  <= SEQ_IDLE;
                    cnt <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/convtrig_ctrl.sv
module convtrig_ctrl
    import convtrig_pkg::*;
#(
    parameter int TMR_W    = 16,
    parameter int SMP_W    = 10,
    parameter int CONV_TAD = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [SMP_W-1:0]  sample_in,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              done_flag,
    output logic [RES_W-1:0]  result
);

    localparam int CNT_W = $clog2(((ACQ_TAD_MAX + CONV_TAD) << TAD_SHIFT_MAX) + 1);
    localparam int HI_W  = TMR_W - BUS_W;
    localparam int PAD_W = RES_W - SMP_W;

    logic              en_q;
    logic [CHAN_W-1:0] chan_q;
    logic              flag_q;
    cfg_t              cfg_q;
    logic [3:0]        mode_q;
    logic [TMR_W-1:0]  cmp_q;

    logic [TMR_W-1:0]  tmr_q;
    logic              trig;
    logic              busy;
    logic              finish;
    logic [SMP_W-1:0]  raw;

    ctrl_view_t        wv;
    ctrl_view_t        rv;
    logic              wr_ctrl;
    logic              en_next;
    logic              start;
    logic              abort;

    always_comb begin
        wv      = ctrl_view_t'(bus_wdata);
        wr_ctrl = bus_wr && (reg_addr_e'(bus_addr) == A_CTRL);
        en_next = wr_ctrl ? wv.en : en_q;
        start   = !busy && en_next && (trig || (wr_ctrl && wv.go));
        abort   = busy && wr_ctrl && (!wv.go || !wv.en);
    end

    convtrig_timer #(
        .TMR_W (TMR_W)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .mode (mode_q),
        .cmp  (cmp_q),
        .tmr  (tmr_q),
        .trig (trig)
    );

    convtrig_seq #(
        .SMP_W    (SMP_W),
        .CONV_TAD (CONV_TAD),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .abort    (abort),
        .acq_code (cfg_q.acq),
        .tad_code (cfg_q.tad),
        .sample   (sample_in),
        .busy     (busy),
        .finish   (finish),
        .raw      (raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            chan_q <= '0;
            cfg_q  <= '0;
            mode_q <= '0;
            cmp_q  <= '0;
        end else if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                A_CTRL: begin
                    en_q   <= wv.en;
                    chan_q <= wv.chan;
                end
                A_CFG: begin
                    cfg_q      <= cfg_t'(bus_wdata);
                    cfg_q.rsvd <= 1'b0;
                end
                A_MODE:   mode_q <= bus_wdata[3:0];
                A_CMP_LO: cmp_q[BUS_W-1:0] <= bus_wdata;
                A_CMP_HI: cmp_q[TMR_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // completion sets the flag; a control write with bit 7 clear drops it
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (finish) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && !wv.flag) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        if (cfg_q.right_just) begin
            result = {{PAD_W{1'b0}}, raw};
        end else begin
            result = {raw, {PAD_W{1'b0}}};
        end
        chan_sel  = chan_q;
        done_flag = flag_q;
        rv        = '{flag: flag_q, rsvd: 1'b0, chan: chan_q, go: busy, en: en_q};
        case (reg_addr_e'(bus_addr))
            A_CTRL:   bus_rdata = rv;
            A_CFG:    bus_rdata = cfg_q;
            A_MODE:   bus_rdata = {4'b0000, mode_q};
            A_CMP_LO: bus_rdata = cmp_q[BUS_W-1:0];
            A_CMP_HI: bus_rdata = BUS_W'(cmp_q[TMR_W-1:BUS_W]);
            A_RES_HI: bus_rdata = result[RES_W-1:BUS_W];
            A_RES_LO: bus_rdata = result[BUS_W-1:0];
            default:  bus_rdata = tmr_q[BUS_W-1:0];
        endcase
    end

endmodule

// File: rtl/convtrig_ctrl_chk.sv
module convtrig_ctrl_chk
    import convtrig_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int SMP_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       mode,
    input logic [TMR_W-1:0] tmr,
    input logic [TMR_W-1:0] cmp,
    input logic             trig,
    input logic             en,
    input logic             busy,
    input logic             flag,
    input logic             bus_wr,
    input logic [SMP_W-1:0] raw
);

    // R3: a compare match in special-event mode zeroes the timer
    a_r3_match_clears_timer: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SPECIAL && tmr == cmp) |=> (tmr == '0))
        else $error("timer not cleared on match");

    // R2: without a match the timer steps by one
    a_r2_timer_steps: assert property (@(posedge clk) disable iff (rst)
        !(mode == MODE_SPECIAL && tmr == cmp) |=> (tmr == TMR_W'($past(tmr) + 1'b1)))
        else $error("timer did not step");

    // R4: an enabled idle converter starts on a trigger
    a_r4_trigger_starts: assert property (@(posedge clk) disable iff (rst)
        (trig && en && !busy && !bus_wr) |=> busy)
        else $error("trigger did not start conversion");

    // R5: nothing runs while the converter is disabled
    a_r5_busy_needs_enable: assert property (@(posedge clk) disable iff (rst)
        busy |-> en)
        else $error("busy while disabled");

    // R7: the flag rises only as a conversion completes
    a_r7_flag_on_completion: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $fell(busy))
        else $error("flag rose without completion");

    // R11: the result only changes at a completion
    a_r11_result_only_on_completion: assert property (@(posedge clk) disable iff (rst)
        !$stable(raw) |-> $fell(busy))
        else $error("result changed outside completion");

endmodule

bind convtrig_ctrl convtrig_ctrl_chk #(
    .TMR_W (TMR_W),
    .SMP_W (SMP_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode_q),
    .tmr    (tmr_q),
    .cmp    (cmp_q),
    .trig   (trig),
    .en     (en_q),
    .busy   (busy),
    .flag   (flag_q),
    .bus_wr (bus_wr),
    .raw    (raw)
);

// File: tb/convtrig_ctrl_test.sv
module convtrig_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [9:0]  sample_in = 10'h000;
    logic [3:0]  chan_sel;
    logic        done_flag;
    logic [15:0] result;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    int base  = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    convtrig_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sample_in (sample_in),
        .chan_sel  (chan_sel),
        .done_flag (done_flag),
        .result    (result)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_to(input int k);
        while (cyc - base < k) @(negedge clk);
    endtask

    task automatic chk_go(input string req, input logic exp);
        logic [7:0] d;
        rd(3'd0, d);
        check(req, {15'd0, d[1]}, {15'd0, exp});
    endtask

    task automatic chk_tmr(input string req, input logic [7:0] exp);
        logic [7:0] d;
        rd(3'd7, d);
        check(req, {8'd0, d}, {8'd0, exp});
    endtask

    // realign: clear compare to 0 on an edge where the old period matches
    task automatic disarm(input int per);
        while (((cyc - base + 2) % per) != 0) @(negedge clk);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 register", {8'd0, d}, 16'h0000);
        end
        check("R1 done_flag", {15'd0, done_flag}, 16'h0000);
        check("R1 result", result, 16'h0000);
        check("R1 chan_sel", {12'd0, chan_sel}, 16'h0000);
    endtask

    task automatic t_free_run();
        base = cyc;
        wr(3'd3, 8'd5);
        chk_tmr("R2 count", 8'd2);
        wait_to(12);
        chk_tmr("R2 passes compare", 8'd12);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h0B);
        repeat (66000) @(negedge clk);
        chk_tmr("R3 wrap and hold", 8'd0);
        chk_go("R5 idle while disabled", 1'b0);
    endtask

    task automatic t_disabled();
        wr(3'd3, 8'd40);
        base = cyc;
        chk_tmr("R5 start", 8'd0);
        wait_to(40);
        chk_tmr("R5 before match", 8'd40);
        wait_to(41);
        chk_tmr("R5 reset at match", 8'd0);
        chk_go("R5 no start", 1'b0);
        wait_to(82);
        chk_tmr("R3 period repeats", 8'd0);
        chk_go("R5 still idle", 1'b0);
        disarm(41);
    endtask

    task automatic t_trigger_conv();
        logic [7:0] d;
        wr(3'd1, 8'h80);
        sample_in = 10'h2A5;
        wr(3'd3, 8'd40);
        base = cyc;
        wr(3'd0, 8'h01);
        wait_to(40);
        chk_go("R4 not yet", 1'b0);
        chk_tmr("R4 timer before", 8'd40);
        wait_to(41);
        chk_go("R4 started", 1'b1);
        chk_tmr("R4 timer zero", 8'd0);
        wait_to(51);
        chk_go("R6 still busy", 1'b1);
        check("R7 flag not yet", {15'd0, done_flag}, 16'h0000);
        wait_to(52);
        chk_go("R6 done", 1'b0);
        check("R7 flag", {15'd0, done_flag}, 16'h0001);
        check("R8 right justified", result, 16'h02A5);
        rd(3'd5, d);
        check("R8 high byte", {8'd0, d}, 16'h0002);
        rd(3'd6, d);
        check("R8 low byte", {8'd0, d}, 16'h00A5);
        chk_tmr("R4 timer runs", 8'd11);
        wr(3'd1, 8'h00);
        check("R8 left justified", result, 16'hA940);
        rd(3'd5, d);
        check("R8 left high", {8'd0, d}, 16'h00A9);
        rd(3'd6, d);
        check("R8 left low", {8'd0, d}, 16'h0040);
        check("R12 flag sticky", {15'd0, done_flag}, 16'h0001);
        wr(3'd0, 8'h81);
        check("R12 bit7 keeps flag", {15'd0, done_flag}, 16'h0001);
        wr(3'd0, 8'h00);
        check("R12 flag cleared", {15'd0, done_flag}, 16'h0000);
        disarm(41);
    endtask

    task automatic t_busy_trigger();
        wr(3'd1, 8'h88);
        wr(3'd3, 8'd5);
        base = cyc;
        wr(3'd0, 8'h01);
        wait_to(13);
        chk_go("R9 busy across trigger", 1'b1);
        wait_to(18);
        chk_go("R9 still busy", 1'b1);
        chk_tmr("R9 timer reset while busy", 8'd0);
        wait_to(19);
        chk_go("R9 original end time", 1'b0);
        check("R9 flag", {15'd0, done_flag}, 16'h0001);
        chk_tmr("R9 timer", 8'd1);
        wait_to(24);
        chk_go("R9 next trigger starts", 1'b1);
        wr(3'd0, 8'h00);
        disarm(6);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_software();
        logic [7:0] d;
        wr(3'd1, 8'hB9);
        sample_in = 10'h3C1;
        wr(3'd0, 8'h02);
        rd(3'd0, d);
        check("R10 go without enable", {8'd0, d}, 16'h0000);
        wr(3'd0, 8'h03);
        base = cyc;
        chk_go("R10 software start", 1'b1);
        wait_to(61);
        chk_go("R6 long busy", 1'b1);
        check("R6 flag not yet", {15'd0, done_flag}, 16'h0000);
        wait_to(62);
        chk_go("R6 long done", 1'b0);
        check("R7 flag sw", {15'd0, done_flag}, 16'h0001);
        check("R7 result sw", result, 16'h03C1);
        wr(3'd0, 8'h01);
        check("R12 clear", {15'd0, done_flag}, 16'h0000);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        wr(3'd1, 8'h80);
        sample_in = 10'h0AA;
        wr(3'd0, 8'h03);
        base = cyc;
        wr(3'd0, 8'h01);
        chk_go("R11 aborted", 1'b0);
        wait_to(20);
        chk_go("R11 stays idle", 1'b0);
        check("R11 no flag", {15'd0, done_flag}, 16'h0000);
        check("R11 result kept", result, 16'h03C1);
        rd(3'd0, d);
        check("R11 enable kept", {8'd0, d}, 16'h0001);
    endtask

    task automatic t_channel();
        logic [7:0] d;
        wr(3'd0, 8'h28);
        check("R13 chan_sel", {12'd0, chan_sel}, 16'h000A);
        rd(3'd0, d);
        check("R13 readback", {8'd0, d}, 16'h0028);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_free_run();
        t_disabled();
        t_trigger_conv();
        t_busy_trigger();
        t_software();
        t_abort();
        t_channel();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule